// File: doc/BRIEF.md
# Strobed Register-Select Bus Front End

This block sits between an asynchronous CPU bus and a peripheral with eight registers. A three-bit register address and three chip-select inputs of mixed polarity go through a latch that an address strobe controls. The latch is transparent while the strobe is low and holds its contents from the strobe's rising edge for as long as it stays high. A bus that multiplexes address and data can therefore present the address once. Where no address strobe exists, the strobe is tied low.

Read and write each have two strobes of opposite polarity, and either one may be used. The qualified read level drives, with no clock, a driver-disable output for an external transceiver and an output enable for the data bus. Both qualified levels pass through a synchronizer into a small access state machine. It has three states: `ACC_IDLE`, `ACC_READ` and `ACC_WRITE`. The transition `ACC_IDLE`→`ACC_WRITE` is taken when a synchronized write is seen, and it has priority. The transition `ACC_IDLE`→`ACC_READ` is taken when only a synchronized read is seen. Both states capture the latched address on entry. `ACC_WRITE`→`ACC_IDLE` fires on the write's trailing edge and issues a one-cycle write pulse. `ACC_READ`→`ACC_IDLE` fires on the read's trailing edge and issues a one-cycle read-done pulse, which the register file uses for side effects such as clear-on-read.

Top module: `strobed_bus_front`

## Requirements
- R1: While `adr_stb_n` is low, `reg_sel_o` follows `reg_sel_in`, and the chip-select inputs take part in selection directly.
- R2: While `adr_stb_n` is high after a rising edge, `reg_sel_o` and the selection keep the values present at that edge, whatever the address and chip-select pins do.
- R3: The device is selected only when the latched `cs_hi_a` is 1, the latched `cs_hi_b` is 1 and the latched `cs_lo_n` is 0. Any other combination deselects it.
- R4: `drv_off` is 0 exactly when the device is selected and (`rd_hi`=1 or `rd_lo_n`=0). Otherwise it is 1.
- R5: `bus_oe` is always the inverse of `drv_off`.
- R6: Every selected write access gives exactly one `wr_stb` pulse, one clock wide. It appears SYNC_STAGES+1 rising edges after the write strobe goes inactive. During the pulse, `acc_addr` holds the latched address and `wr_data` holds the last `bus_din` value sampled while the write was active.
- R7: Every selected read access gives exactly one `rd_done` pulse, one clock wide. It appears SYNC_STAGES+1 rising edges after the read strobe goes inactive, with `acc_addr` holding the latched address.
- R8: An unselected access produces no pulse. If a read and a write are active together, only the write pulse is issued.
- R9: After reset, with no strobe active, `rd_done` and `wr_stb` are 0, `drv_off` is 1 and `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| adr_stb_n | input | 1 | Address strobe: low means transparent, high means hold |
| reg_sel_in | input | AW | Register address pins |
| cs_hi_a | input | 1 | Chip select, active high |
| cs_hi_b | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| rd_hi | input | 1 | Read strobe, active high |
| rd_lo_n | input | 1 | Read strobe, active low |
| wr_hi | input | 1 | Write strobe, active high |
| wr_lo_n | input | 1 | Write strobe, active low |
| bus_din | input | DW | Write data from the CPU bus |
| drv_off | output | 1 | Transceiver driver disable, high unless a selected read is in progress |
| bus_oe | output | 1 | Data bus output enable |
| reg_sel_o | output | AW | Latched register address to the read mux |
| rd_done | output | 1 | One-cycle read trailing-edge pulse |
| wr_stb | output | 1 | One-cycle register write pulse |
| acc_addr | output | AW | Address captured for the current access |
| wr_data | output | DW | Write data captured for the current access |

## Verification
The bench scrambles the address and chip-select pins after the address strobe has risen. A design that tracked the pins instead of holding them would write to a wrong register or drop the access. Every one of the eight chip-select polarity combinations is tried on both strobe polarities. A decoder with an inverted term would drive the bus or issue pulses for foreign accesses. The bench measures pulse latency to the exact edge and counts pulses per access, which catches double pulses and pulses issued on the leading edge. It also runs a read and a write together to confirm that only the write pulse is issued.

// File: rtl/busfe_pkg.sv
`timescale 1ns/1ps
package busfe_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_state_t;
endpackage

// File: rtl/sel_latch.sv
`timescale 1ns/1ps
module sel_latch #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_n,
    input  logic [AW-1:0] addr_in,
    input  logic          cs_a,
    input  logic          cs_b,
    input  logic          cs_c_n,
    output logic [AW-1:0] addr_o,
    output logic          sel_o
);
    logic [AW-1:0] addr_q;
    logic          a_q, b_q, c_q;

    // Transparent while the strobe is low, holds from the rising edge.
    always_latch begin
        if (!stb_n) begin
            addr_q <= addr_in;
            a_q    <= cs_a;
            b_q    <= cs_b;
            c_q    <= cs_c_n;
        end
    end

    assign addr_o = addr_q;
    assign sel_o  = a_q & b_q & ~c_q;

    assert_hold_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_n && $past(stb_n)) |-> $stable(addr_q));
    assert_hold_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_n && $past(stb_n)) |-> $stable(sel_o));
endmodule

// File: rtl/lvl_sync.sv
`timescale 1ns/1ps
module lvl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/acc_fsm.sv
`timescale 1ns/1ps
module acc_fsm
    import busfe_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_s,
    input  logic          wr_s,
    input  logic          wr_raw,
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] addr_in,
    output logic          rd_done,
    output logic          wr_stb,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] wr_data
);
    acc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: begin
                if (wr_s)      state_d = ACC_WRITE;
                else if (rd_s) state_d = ACC_READ;
            end
            ACC_READ:  if (!rd_s) state_d = ACC_IDLE;
            ACC_WRITE: if (!wr_s) state_d = ACC_IDLE;
            default:   state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_done  <= 1'b0;
            wr_stb   <= 1'b0;
            acc_addr <= '0;
            wr_data  <= '0;
        end else begin
            rd_done <= (state_q == ACC_READ)  && (state_d == ACC_IDLE);
            wr_stb  <= (state_q == ACC_WRITE) && (state_d == ACC_IDLE);
            if (state_q == ACC_IDLE && state_d != ACC_IDLE) acc_addr <= addr_in;
            if (wr_raw) wr_data <= din;
        end
    end

    assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    assert_rd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);
    assert_excl_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, rd_done}));
    assert_wr_after_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !$past(wr_s));
endmodule

// File: rtl/strobed_bus_front.sv
`timescale 1ns/1ps
module strobed_bus_front #(
    parameter int AW          = 3,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adr_stb_n,
    input  logic [AW-1:0] reg_sel_in,
    input  logic          cs_hi_a,
    input  logic          cs_hi_b,
    input  logic          cs_lo_n,
    input  logic          rd_hi,
    input  logic          rd_lo_n,
    input  logic          wr_hi,
    input  logic          wr_lo_n,
    input  logic [DW-1:0] bus_din,
    output logic          drv_off,
    output logic          bus_oe,
    output logic [AW-1:0] reg_sel_o,
    output logic          rd_done,
    output logic          wr_stb,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] wr_data
);
    logic cs_sel, rd_lvl, wr_lvl, rd_s, wr_s;

    sel_latch #(.AW(AW)) u_latch (
        .clk(clk), .rst_n(rst_n), .stb_n(adr_stb_n), .addr_in(reg_sel_in),
        .cs_a(cs_hi_a), .cs_b(cs_hi_b), .cs_c_n(cs_lo_n),
        .addr_o(reg_sel_o), .sel_o(cs_sel)
    );

    assign rd_lvl  = cs_sel & (rd_hi | ~rd_lo_n);
    assign wr_lvl  = cs_sel & (wr_hi | ~wr_lo_n);
    assign bus_oe  = rd_lvl;
    assign drv_off = ~rd_lvl;

    lvl_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .d(rd_lvl), .q(rd_s));
    lvl_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .d(wr_lvl), .q(wr_s));

    acc_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_s(rd_s), .wr_s(wr_s), .wr_raw(wr_lvl),
        .din(bus_din), .addr_in(reg_sel_o), .rd_done(rd_done), .wr_stb(wr_stb),
        .acc_addr(acc_addr), .wr_data(wr_data)
    );

    assert_oe_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> cs_sel);
    assert_oe_vs_drv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe != drv_off);
    assert_oe_needs_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (rd_hi || !rd_lo_n));
endmodule

// File: tb/tb_strobed_bus_front.sv
`timescale 1ns/1ps
module tb_strobed_bus_front;
    localparam int AW = 3, DW = 8, SYNC = 2, LAT = SYNC + 1;

    logic clk = 0, rst_n = 0;
    logic adr_stb_n = 1;
    logic [AW-1:0] reg_sel_in = '0;
    logic cs_hi_a = 0, cs_hi_b = 0, cs_lo_n = 1;
    logic rd_hi = 0, rd_lo_n = 1, wr_hi = 0, wr_lo_n = 1;
    logic [DW-1:0] bus_din = '0;
    logic drv_off, bus_oe, rd_done, wr_stb;
    logic [AW-1:0] reg_sel_o, acc_addr;
    logic [DW-1:0] wr_data;

    strobed_bus_front #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC)) dut (.*);

    always #2 clk = ~clk;

    int cyc = 0, n_chk = 0, n_err = 0;
    int wr_cnt = 0, rd_cnt = 0, wr_cyc = 0, rd_cyc = 0;
    logic [AW-1:0] wr_a, rd_a;
    logic [DW-1:0] wr_d;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (wr_stb) begin wr_cnt++; wr_cyc = cyc; wr_a = acc_addr; wr_d = wr_data; end
        if (rd_done) begin rd_cnt++; rd_cyc = cyc; rd_a = acc_addr; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_sel(input logic [2:0] cs);
        return cs[0] && cs[1] && !cs[2];
    endfunction

    // cs = {cs_lo_n, cs_hi_b, cs_hi_a}; kind: 0 read, 1 write, 2 both; pol: 0 high strobe, 1 low strobe
    task automatic access(input logic [AW-1:0] a, input logic [2:0] cs, input int kind,
                          input bit pol, input logic [DW-1:0] d);
        int w0, r0, rel;
        bit s;
        s = exp_sel(cs);
        @(negedge clk);
        adr_stb_n = 0; reg_sel_in = a; {cs_lo_n, cs_hi_b, cs_hi_a} = cs;
        #0.5 chk(reg_sel_o == a, "R1 transparent", reg_sel_o, a);
        @(negedge clk);
        adr_stb_n = 1;
        @(negedge clk);
        reg_sel_in = ~a; {cs_lo_n, cs_hi_b, cs_hi_a} = ~cs;
        #0.5 chk(reg_sel_o == a, "R2 hold", reg_sel_o, a);
        w0 = wr_cnt; r0 = rd_cnt;
        @(negedge clk);
        bus_din = d;
        if (kind != 0) begin if (pol) wr_lo_n = 0; else wr_hi = 1; end
        if (kind != 1) begin if (pol) rd_lo_n = 0; else rd_hi = 1; end
        #0.5;
        chk(drv_off == !(s && kind != 1), "R4 drv_off", drv_off, !(s && kind != 1));
        chk(bus_oe == !drv_off, "R5 bus_oe", bus_oe, !drv_off);
        repeat (4) @(negedge clk);
        wr_hi = 0; wr_lo_n = 1; rd_hi = 0; rd_lo_n = 1; bus_din = ~d;
        rel = cyc;
        #0.5 chk(drv_off == 1, "R4 drv_off idle", drv_off, 1);
        repeat (LAT + 3) @(negedge clk);
        if (!s) begin
            chk(wr_cnt == w0 && rd_cnt == r0, "R3/R8 unselected no pulse", wr_cnt + rd_cnt, w0 + r0);
        end else if (kind != 0) begin
            chk(wr_cnt == w0 + 1, "R6 one write pulse", wr_cnt - w0, 1);
            chk(wr_cyc == rel + LAT, "R6 latency", wr_cyc - rel, LAT);
            chk(wr_a == a, "R6 address", wr_a, a);
            chk(wr_d == d, "R6 data", wr_d, d);
            chk(rd_cnt == r0, "R8 write priority", rd_cnt - r0, 0);
        end else begin
            chk(rd_cnt == r0 + 1, "R7 one read pulse", rd_cnt - r0, 1);
            chk(rd_cyc == rel + LAT, "R7 latency", rd_cyc - rel, LAT);
            chk(rd_a == a, "R7 address", rd_a, a);
            chk(wr_cnt == w0, "R7 no write", wr_cnt - w0, 0);
        end
    endtask

    initial begin
        int unused;
        unused = $urandom(1234);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rd_done == 0 && wr_stb == 0, "R9 no pulses", rd_done + wr_stb, 0);
        chk(drv_off == 1, "R9 drv_off", drv_off, 1);
        chk(bus_oe == 0, "R9 bus_oe", bus_oe, 0);
        // directed: every chip-select combination, both polarities
        for (int c = 0; c < 8; c++) begin
            access(3'(c), 3'(c), 0, c[0], 8'h00);
            access(3'(7 - c), 3'(c), 1, !c[0], 8'(8'hA0 + c));
        end
        access(3'd5, 3'b011, 2, 1'b0, 8'h5C);
        access(3'd2, 3'b011, 2, 1'b1, 8'hC3);
        // constrained random
        for (int k = 0; k < 40; k++) begin
            logic [2:0] cs;
            cs = ($urandom % 3 != 0) ? 3'b011 : 3'($urandom);
            access(3'($urandom), cs, int'($urandom % 3), 1'($urandom), 8'($urandom));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule